// File: doc/BRIEF.md
# Half-Duplex Inter-Packet Gap Deference Timer

This block tells a MAC transmitter when it may begin its next frame. It times the inter-packet gap in bit times, counting one step per bit-time tick. Timing starts when the medium goes quiet: either the local transmitter finishes, or carrier from another station drops. The gap is split into two windows. The first window, `win_sense`, is the part of the gap in which the block still listens for carrier. Carrier seen during that window makes the block defer: it waits for carrier to drop and then starts the whole gap again. Carrier that appears after the first window has closed is ignored on purpose. The block then finishes the full gap, `win_total`, and permits transmission, accepting that a collision may follow. This keeps access to a shared medium fair.

In full-duplex mode carrier sense plays no part. The grant follows purely from `win_total` bit times after the end of the previous local transmission.

Once the gap is complete, the grant is offered to a pending request. It stays up until the transmitter shows, through `tx_busy`, that a frame has started. At that point the timer clears and waits for the frame to end.

Top module: `ipg_defer_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, `tx_grant` is 0.
- R2: Suppose ticks arrive every cycle and nothing interrupts the gap. Count the first clock edge at which `tx_busy` is low (and, in half duplex, carrier is low) as edge 1. Then `tx_grant` is first 1 after edge `win_total`+2.
- R3: In half duplex, carrier seen while fewer than min(`win_sense`,`win_total`) ticks have elapsed in the gap makes the block defer. The gap restarts from zero at the first edge with carrier low again.
- R4: In half duplex, carrier that appears once at least min(`win_sense`,`win_total`) ticks have elapsed does not delay the grant. This includes carrier present while the grant is up with a request pending.
- R5: When `win_sense` is greater than `win_total`, the sensing window is `win_total` ticks long.
- R6: When `full_duplex`=1, `crs` has no effect, and the grant timing is that of R2 for any carrier pattern.
- R7: The gap count advances only on cycles with `bit_tick`=1. With no ticks the grant never comes; once ticks resume, the grant is first 1 after `win_total`+1 further edges.
- R8: `tx_grant` is 1 only while the gap is complete and `tx_req`=1. It follows `tx_req` in the same cycle and stays up while `tx_req` is held.
- R9: `tx_busy`=1 forces `tx_grant` to 0 in the same cycle and clears the gap. Timing restarts from the first edge with `tx_busy` low.
- R10: In half duplex, carrier seen while the gap is complete but no request is pending sends the block back to deference. A full gap is then timed again after carrier drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| crs | input | 1 | Carrier sense from the PHY |
| tx_req | input | 1 | A frame is waiting to be sent |
| tx_busy | input | 1 | Local transmitter is sending a frame |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| win_sense | input | GAP_W | Carrier-sense window in bit times |
| win_total | input | GAP_W | Full inter-packet gap in bit times |
| tx_grant | output | 1 | Transmission permitted |

## Verification
The bench builds the timer with the default `GAP_W` of 7. It drives only small window values: `win_total` from 0 to 7 and `win_sense` from 0 to 9. This keeps every trial short, so it can sweep every window pair against every carrier arrival offset, from inside the sensing window to past completion, in both duplex modes. Because `win_sense` runs past `win_total` in the sweep, the clamping case is covered too. Dedicated trials cover tick starvation, request gating, a frame start that cancels the grant, and carrier arriving while the gap is complete with no request pending.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_GAP   = 2'd1,
    ST_READY = 2'd2
  } ipg_state_e;

  // Effective sensing window: never longer than the full gap.
  function automatic logic [15:0] clamp_window(input logic [15:0] sense,
                                               input logic [15:0] total);
    return (sense > total) ? total : sense;
  endfunction

  // Still inside the carrier-sense part of the gap.
  function automatic logic in_sense_window(input logic [15:0] elapsed,
                                           input logic [15:0] sense_eff);
    return elapsed < sense_eff;
  endfunction

  // Whole gap has been timed.
  function automatic logic gap_reached(input logic [15:0] elapsed,
                                       input logic [15:0] total);
    return elapsed >= total;
  endfunction

endpackage

// File: rtl/ipg_window_cfg.sv
module ipg_window_cfg
  import ipg_pkg::*;
#(
  parameter int GAP_W = 7
) (
  input  logic [GAP_W-1:0] win_sense,
  input  logic [GAP_W-1:0] win_total,
  output logic [GAP_W-1:0] sense_eff,
  output logic [GAP_W-1:0] total_eff
);
  localparam int PADW = 16 - GAP_W;

  logic [15:0] sense_w;
  logic [15:0] total_w;
  logic [15:0] clamped;

  always_comb begin
    sense_w = {{PADW{1'b0}}, win_sense};
    total_w = {{PADW{1'b0}}, win_total};
    clamped = clamp_window(sense_w, total_w);
  end

  assign sense_eff = clamped[GAP_W-1:0];
  assign total_eff = win_total;
endmodule

// File: rtl/ipg_gap_counter.sv
module ipg_gap_counter #(
  parameter int GAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [GAP_W-1:0] elapsed
);
  always_ff @(posedge clk) begin
    if (!rst_n)       elapsed <= '0;
    else if (clear)   elapsed <= '0;
    else if (advance) elapsed <= elapsed + 1'b1;
  end
endmodule

// File: rtl/ipg_defer_fsm.sv
module ipg_defer_fsm
  import ipg_pkg::*;
#(
  parameter int GAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             crs,
  input  logic             tx_req,
  input  logic             tx_busy,
  input  logic             full_duplex,
  input  logic [GAP_W-1:0] elapsed,
  input  logic [GAP_W-1:0] sense_eff,
  input  logic [GAP_W-1:0] total_eff,
  output ipg_state_e       state,
  output logic             cnt_clear,
  output logic             cnt_advance,
  output logic             defer_evt,
  output logic             gap_done_evt,
  output logic             abandon_evt
);
  localparam int PADW = 16 - GAP_W;

  ipg_state_e  state_nxt;
  logic        carrier_seen;
  logic        medium_idle;
  logic [15:0] elapsed_w;
  logic [15:0] sense_w;
  logic [15:0] total_w;

  assign elapsed_w    = {{PADW{1'b0}}, elapsed};
  assign sense_w      = {{PADW{1'b0}}, sense_eff};
  assign total_w      = {{PADW{1'b0}}, total_eff};
  assign carrier_seen = crs && !full_duplex;
  assign medium_idle  = !tx_busy && !carrier_seen;

  assign defer_evt    = (state == ST_GAP) && !tx_busy && carrier_seen &&
                        in_sense_window(elapsed_w, sense_w);
  assign gap_done_evt = (state == ST_GAP) && !tx_busy && !defer_evt &&
                        gap_reached(elapsed_w, total_w);
  assign abandon_evt  = (state == ST_READY) && !tx_busy && !tx_req && carrier_seen;

  always_comb begin
    state_nxt = state;
    if (tx_busy) begin
      state_nxt = ST_WAIT;
    end else begin
      unique case (state)
        ST_WAIT:  if (medium_idle) state_nxt = ST_GAP;
        ST_GAP: begin
          if (defer_evt)         state_nxt = ST_WAIT;
          else if (gap_done_evt) state_nxt = ST_READY;
        end
        ST_READY: if (abandon_evt) state_nxt = ST_WAIT;
        default:  state_nxt = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_WAIT;
    else        state <= state_nxt;
  end

  assign cnt_clear   = (state != ST_GAP) || tx_busy || defer_evt;
  assign cnt_advance = (state == ST_GAP) && bit_tick && !gap_done_evt;
endmodule

// File: rtl/ipg_defer_timer.sv
module ipg_defer_timer
  import ipg_pkg::*;
#(
  parameter int GAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             crs,
  input  logic             tx_req,
  input  logic             tx_busy,
  input  logic             full_duplex,
  input  logic [GAP_W-1:0] win_sense,
  input  logic [GAP_W-1:0] win_total,
  output logic             tx_grant
);
  logic [GAP_W-1:0] sense_eff;
  logic [GAP_W-1:0] total_eff;
  logic [GAP_W-1:0] elapsed;
  ipg_state_e       state;
  logic             cnt_clear;
  logic             cnt_advance;
  logic             defer_evt;
  logic             gap_done_evt;
  logic             abandon_evt;
  logic             gap_active;

  ipg_window_cfg #(.GAP_W(GAP_W)) u_cfg (
    .win_sense (win_sense),
    .win_total (win_total),
    .sense_eff (sense_eff),
    .total_eff (total_eff)
  );

  ipg_gap_counter #(.GAP_W(GAP_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cnt_clear),
    .advance (cnt_advance),
    .elapsed (elapsed)
  );

  ipg_defer_fsm #(.GAP_W(GAP_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .crs          (crs),
    .tx_req       (tx_req),
    .tx_busy      (tx_busy),
    .full_duplex  (full_duplex),
    .elapsed      (elapsed),
    .sense_eff    (sense_eff),
    .total_eff    (total_eff),
    .state        (state),
    .cnt_clear    (cnt_clear),
    .cnt_advance  (cnt_advance),
    .defer_evt    (defer_evt),
    .gap_done_evt (gap_done_evt),
    .abandon_evt  (abandon_evt)
  );

  assign gap_active = (state == ST_GAP);
  assign tx_grant   = (state == ST_READY) && tx_req && !tx_busy;
endmodule

// File: rtl/ipg_defer_checker.sv
module ipg_defer_checker #(
  parameter int GAP_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             crs,
  input logic             tx_req,
  input logic             tx_busy,
  input logic             full_duplex,
  input logic             tx_grant,
  input logic             gap_active,
  input logic             defer_evt,
  input logic             gap_done_evt,
  input logic [GAP_W-1:0] elapsed,
  input logic [GAP_W-1:0] sense_eff,
  input logic [GAP_W-1:0] total_eff
);
  // R9: a frame in progress never sees a grant
  p_no_grant_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_grant);

  // R8: grant only toward a pending request
  p_grant_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> tx_req);

  // R6: full duplex never defers
  p_fd_no_defer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |-> !defer_evt);

  // R4: carrier past the sensing window causes no deference
  p_late_carrier_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_active && crs && (elapsed >= sense_eff)) |-> !defer_evt);

  // R5: effective sensing window is bounded by the full gap
  p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sense_eff <= total_eff);

  // R7: without a tick the count holds while the gap keeps running
  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_active && !bit_tick && !defer_evt && !tx_busy) |=> $stable(elapsed));

  // R2: completion only once the full gap has been counted
  p_done_after_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gap_done_evt |-> (elapsed >= total_eff));

  // R3: deference returns the count to zero
  p_defer_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    defer_evt |=> (elapsed == '0));
endmodule

bind ipg_defer_timer ipg_defer_checker #(.GAP_W(GAP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_tick     (bit_tick),
  .crs          (crs),
  .tx_req       (tx_req),
  .tx_busy      (tx_busy),
  .full_duplex  (full_duplex),
  .tx_grant     (tx_grant),
  .gap_active   (gap_active),
  .defer_evt    (defer_evt),
  .gap_done_evt (gap_done_evt),
  .elapsed      (elapsed),
  .sense_eff    (sense_eff),
  .total_eff    (total_eff)
);

// File: tb/tb_ipg_defer_timer.sv
module tb_ipg_defer_timer;
  localparam int GAP_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bit_tick = 1'b1;
  logic             crs = 1'b0;
  logic             tx_req = 1'b0;
  logic             tx_busy = 1'b0;
  logic             full_duplex = 1'b0;
  logic [GAP_W-1:0] win_sense = '0;
  logic [GAP_W-1:0] win_total = '0;
  logic             tx_grant;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  ipg_defer_timer #(.GAP_W(GAP_W)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .crs         (crs),
    .tx_req      (tx_req),
    .tx_busy     (tx_busy),
    .full_duplex (full_duplex),
    .win_sense   (win_sense),
    .win_total   (win_total),
    .tx_grant    (tx_grant)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_tests = n_tests + 1;
      n_fail  = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Frame start/end, optional carrier pulse at offset m; returns edge index of first grant.
  task automatic run_trial(input int s, input int t, input logic fd, input int m,
                           output int got);
    @(negedge clk);
    win_sense = GAP_W'(s); win_total = GAP_W'(t); full_duplex = fd;
    tx_req = 1'b1; tx_busy = 1'b1; crs = 1'b1;
    @(negedge clk);
    tx_busy = 1'b0; crs = 1'b0;
    got = -1;
    for (int e = 1; e <= 60; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (tx_grant) begin got = e; break; end
      crs = (e == m + 1);
    end
    crs = 1'b0;
  endtask

  // Counts edges until grant from now; inputs already set at a negedge.
  task automatic count_to_grant(output int got);
    got = -1;
    for (int e = 1; e <= 60; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (tx_grant) begin got = e; break; end
    end
  endtask

  initial begin
    int got, exp, p1e;
    bit ok_all;

    // R1: reset
    repeat (3) @(negedge clk);
    check(tx_grant == 1'b0, "R1 grant during reset", tx_grant, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(tx_grant == 1'b0, "R1 grant after reset", tx_grant, 0);

    // R2/R3/R4/R5 half-duplex sweep
    for (int t = 0; t <= 7; t++) begin
      for (int s = 0; s <= 9; s++) begin
        for (int m = 0; m <= t + 1; m++) begin
          run_trial(s, t, 1'b0, m, got);
          p1e = (s > t) ? t : s;
          exp = (m < p1e) ? (m + t + 4) : (t + 2);
          if (s > t)        check(got == exp, "R5 clamped window", got, exp);
          else if (m < p1e) check(got == exp, "R3 defer in window", got, exp);
          else              check(got == exp, "R4 late carrier ignored", got, exp);
        end
      end
    end

    // R6 full duplex: carrier never matters
    for (int t = 0; t <= 7; t++) begin
      for (int m = 0; m <= t + 1; m++) begin
        run_trial(t, t, 1'b1, m, got);
        check(got == t + 2, "R6 full duplex timing", got, t + 2);
      end
    end

    // R2 plain gap, no carrier after release
    run_trial(3, 5, 1'b0, 100, got);
    check(got == 7, "R2 plain gap", got, 7);

    // R7: no ticks, no grant
    @(negedge clk);
    full_duplex = 1'b0; win_sense = 7'd2; win_total = 7'd5;
    tx_req = 1'b1; tx_busy = 1'b1; bit_tick = 1'b0;
    @(negedge clk);
    tx_busy = 1'b0;
    ok_all = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); @(negedge clk);
      if (tx_grant) ok_all = 1'b0;
    end
    check(ok_all, "R7 no grant without ticks", ok_all, 1);
    bit_tick = 1'b1;
    count_to_grant(got);
    check(got == 6, "R7 grant after ticks resume", got, 6);

    // R9: frame start drops grant at once, restart from its end
    tx_busy = 1'b1;
    #1;
    check(tx_grant == 1'b0, "R9 busy kills grant", tx_grant, 0);
    @(posedge clk); @(negedge clk);
    tx_busy = 1'b0;
    count_to_grant(got);
    check(got == 7, "R9 restart after frame", got, 7);

    // R8: grant gated by request
    @(negedge clk);
    tx_req = 1'b0; tx_busy = 1'b1;
    @(negedge clk);
    tx_busy = 1'b0;
    repeat (12) begin @(posedge clk); @(negedge clk); end
    check(tx_grant == 1'b0, "R8 no grant without request", tx_grant, 0);
    tx_req = 1'b1;
    #1;
    check(tx_grant == 1'b1, "R8 grant follows request", tx_grant, 1);
    // R4: carrier while granted with pending request is ignored
    crs = 1'b1;
    ok_all = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      if (!tx_grant) ok_all = 1'b0;
    end
    check(ok_all, "R4 grant held through carrier", ok_all, 1);

    // R10: request withdrawn with carrier -> defer again
    tx_req = 1'b0;
    @(posedge clk); @(negedge clk);
    crs = 1'b0; tx_req = 1'b1;
    #1;
    check(tx_grant == 1'b0, "R10 back to deference", tx_grant, 0);
    count_to_grant(got);
    check(got == 7, "R10 full gap retimed", got, 7);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule